// File: doc/BRIEF.md
# Periodic Down-Counting Slice Timer

This block is a 32-bit down-counter behind a small synchronous register bus. Software loads a reload value and sets an enable bit. The counter then loads that value and decrements by one on every clock. When it passes from one to zero, the counter has expired. Expiry sets a sticky expiry flag. The flag drives a level interrupt request whenever interrupts are enabled.

The timer has two modes:

- **Run bit clear:** the counter parks at zero after expiry. It reloads only when software acknowledges the flag by writing a one to it. The interval is therefore the programmed count plus the acknowledge delay.
- **Run bit set:** the counter reloads itself at expiry and keeps going. Expiries then fall exactly every reload-value clocks, whatever software does.

The bus has four word registers, selected by a 2-bit address:

| Address | Register | Access |
|---|---|---|
| 0 | Reload value | read/write |
| 1 | Control | read/write |
| 2 | Current count | read only |
| 3 | Status | write one to clear |

Read data is combinational from the addressed register.

Top module: `slice_timer`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: The reload register (address 0) reads back what was written. Control (address 1) keeps only bit 26 (run), bit 25 (interrupt enable) and bit 24 (timer enable); all its other bits read zero. Writes to the count register (address 2) are ignored.
- R3: A control write that takes timer enable from 0 to 1 loads the counter from the reload value at that clock edge. While enabled, the counter then drops by one per clock.
- R4: Expiry is the clock edge at which an enabled counter at 1 would step. At expiry, status bit 24 sets, so status reads 0x01000000. Status never sets otherwise.
- R5: With run clear, the counter moves to 0 at expiry and holds 0. It reloads from the reload value only at the edge where a one is written to status bit 24.
- R6: With run set, the counter reloads from the reload value at expiry. The count sequence therefore repeats exactly every reload-value clocks, and the flag sets at each expiry.
- R7: Writing a one to status bit 24 clears the flag. Writing zero there leaves the flag unchanged.
- R8: `irq` is high exactly when the flag and interrupt enable are both set. The flag sets even while interrupts are disabled. Enabling interrupts after an earlier expiry raises `irq` from the next cycle.
- R9: Clearing timer enable freezes the counter at its current value.
- R10: When a clear of the flag and an expiry fall on the same clock edge, the flag ends up set.
- R11: A reload value of zero never expires. The counter stays at 0 and the flag stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | 2 | Word address: 0 reload, 1 control, 2 count, 3 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| irq | output | 1 | Level interrupt request |

## Verification
Expiry and the software acknowledge both drive the status flag, and they can land on the same clock edge. The bench provokes this in periodic mode. It polls the count until it reads 1, then issues the write-one-to-clear in that same low phase, so the write lands on the expiring edge. It then judges that the flag still reads set and that the counter has reloaded. A second acknowledge, away from expiry, must then clear the flag.

// File: rtl/slt_pkg.sv
package slt_pkg;
  localparam int unsigned SLT_DW = 32;
  localparam int unsigned SLT_AW = 2;

  typedef logic [SLT_DW-1:0] slt_word_t;

  localparam logic [SLT_AW-1:0] A_RELOAD = 2'd0;
  localparam logic [SLT_AW-1:0] A_CTRL   = 2'd1;
  localparam logic [SLT_AW-1:0] A_COUNT  = 2'd2;
  localparam logic [SLT_AW-1:0] A_STAT   = 2'd3;

  localparam int unsigned B_TEN  = 24;
  localparam int unsigned B_IEN  = 25;
  localparam int unsigned B_RUN  = 26;
  localparam int unsigned B_FLAG = 24;

  // Next counter value; priority: enable-load, frozen, expiry, parked, step.
  function automatic slt_word_t slt_next_count(
    input slt_word_t cur, input slt_word_t reload,
    input logic ten, input logic load, input logic run, input logic ack);
    if (load)                     return reload;
    if (!ten)                     return cur;
    if (cur == slt_word_t'(1))    return run ? reload : '0;
    if (cur == '0)                return ack ? reload : cur;
    return cur - slt_word_t'(1);
  endfunction
endpackage

// File: rtl/slt_regs.sv
module slt_regs
  import slt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [SLT_AW-1:0] bus_addr,
  input  slt_word_t         bus_wdata,
  input  slt_word_t         cnt,
  input  logic              flag,
  output slt_word_t         bus_rdata,
  output slt_word_t         reload,
  output logic              ten,
  output logic              ien,
  output logic              run,
  output logic              load,
  output logic              ack
);
  logic wr_reload, wr_ctrl;

  assign wr_reload = bus_sel && bus_wr && (bus_addr == A_RELOAD);
  assign wr_ctrl   = bus_sel && bus_wr && (bus_addr == A_CTRL);
  assign ack       = bus_sel && bus_wr && (bus_addr == A_STAT) && bus_wdata[B_FLAG];
  assign load      = wr_ctrl && bus_wdata[B_TEN] && !ten;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload <= '0;
      ten    <= 1'b0;
      ien    <= 1'b0;
      run    <= 1'b0;
    end else begin
      if (wr_reload) reload <= bus_wdata;
      if (wr_ctrl) begin
        ten <= bus_wdata[B_TEN];
        ien <= bus_wdata[B_IEN];
        run <= bus_wdata[B_RUN];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_RELOAD: bus_rdata = reload;
      A_CTRL: begin
        bus_rdata[B_TEN] = ten;
        bus_rdata[B_IEN] = ien;
        bus_rdata[B_RUN] = run;
      end
      A_COUNT:  bus_rdata = cnt;
      default:  bus_rdata[B_FLAG] = flag;
    endcase
  end

  a_r3_load_only_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ten);
endmodule

// File: rtl/slt_counter.sv
module slt_counter
  import slt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  slt_word_t reload,
  input  logic      ten,
  input  logic      run,
  input  logic      load,
  input  logic      ack,
  output slt_word_t cnt,
  output logic      expire
);
  slt_word_t cnt_nx;

  assign expire = ten && (cnt == slt_word_t'(1));
  assign cnt_nx = slt_next_count(cnt, reload, ten, load, run, ack);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nx;
  end

  a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (ten && !load && cnt > slt_word_t'(1)) |=> (cnt == $past(cnt) - slt_word_t'(1)));
  a_r5_parked_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ten && cnt == '0 && !ack) |=> (cnt == '0));
  a_r6_periodic_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && run) |=> (cnt == $past(reload)));
  a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!ten && !load) |=> $stable(cnt));
endmodule

// File: rtl/slt_status.sv
module slt_status (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic ack,
  input  logic ien,
  output logic flag,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag <= 1'b0;
    else if (expire) flag <= 1'b1;
    else if (ack)    flag <= 1'b0;
  end

  assign irq = flag && ien;

  a_r10_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag);
  a_r7_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !expire) |=> !flag);
  a_r4_sets_only_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !expire) |=> !flag);
endmodule

// File: rtl/slice_timer.sv
module slice_timer
  import slt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [SLT_AW-1:0] bus_addr,
  input  logic [SLT_DW-1:0] bus_wdata,
  output logic [SLT_DW-1:0] bus_rdata,
  output logic              irq
);
  slt_word_t reload, cnt;
  logic ten, ien, run, load, ack, expire, flag;

  slt_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt(cnt), .flag(flag),
    .bus_rdata(bus_rdata), .reload(reload), .ten(ten), .ien(ien),
    .run(run), .load(load), .ack(ack)
  );

  slt_counter u_counter (
    .clk(clk), .rst_n(rst_n), .reload(reload), .ten(ten), .run(run),
    .load(load), .ack(ack), .cnt(cnt), .expire(expire)
  );

  slt_status u_status (
    .clk(clk), .rst_n(rst_n), .expire(expire), .ack(ack), .ien(ien),
    .flag(flag), .irq(irq)
  );

  a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (ien && flag));
endmodule

// File: tb/tb_slice_timer.sv
`timescale 1ns/1ps
module tb_slice_timer;
  localparam logic [1:0] AR = 2'd0, AC = 2'd1, AN = 2'd2, AS = 2'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = AN;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq;

  int vectors = 0, miscompares = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  slice_timer dut (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  // Behavioural reference state
  longint unsigned m_reload = 0, m_cnt = 0;
  bit m_ten = 0, m_ien = 0, m_run = 0, m_flag = 0;

  always @(posedge clk) begin
    bit wr_c, ackw, fire;
    longint unsigned nc;
    if (!rst_n) begin
      m_reload = 0; m_cnt = 0; m_ten = 0; m_ien = 0; m_run = 0; m_flag = 0;
    end else begin
      wr_c = bus_sel && bus_wr && bus_addr == AC;
      ackw = bus_sel && bus_wr && bus_addr == AS && bus_wdata[24];
      fire = m_ten && m_cnt == 1;
      nc = m_cnt;
      if (wr_c && bus_wdata[24] && !m_ten) nc = m_reload;
      else if (m_ten) begin
        if (fire) nc = m_run ? m_reload : 0;
        else if (m_cnt == 0) begin if (ackw) nc = m_reload; end
        else nc = m_cnt - 1;
      end
      if (fire) m_flag = 1; else if (ackw) m_flag = 0;
      if (wr_c) begin m_ten = bus_wdata[24]; m_ien = bus_wdata[25]; m_run = bus_wdata[26]; end
      if (bus_sel && bus_wr && bus_addr == AR) m_reload = bus_wdata;
      m_cnt = nc;
    end
  end

  function automatic logic [31:0] model_read(input logic [1:0] a);
    case (a)
      AR: return m_reload[31:0];
      AC: return {5'd0, m_run, m_ien, m_ten, 24'd0};
      AN: return m_cnt[31:0];
      default: return {7'd0, m_flag, 24'd0};
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (rst_n && !finished) begin
      check("R3 R5 R6 model rdata", bus_rdata, model_read(bus_addr));
      check("R8 model irq", {31'd0, irq}, {31'd0, m_ien && m_flag});
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_addr = AN; bus_wdata = '0;
    #2;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a; #0.1;
    check(tag, bus_rdata, exp);
    bus_addr = AN; #0.1;
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    check(tag, {31'd0, irq}, {31'd0, exp});
  endtask

  task automatic finish_run();
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    miscompares++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; #2;
    // R1 reset state
    rd(AR, 0, "R1 reload"); rd(AC, 0, "R1 ctrl"); rd(AN, 0, "R1 count"); rd(AS, 0, "R1 status");
    chk_irq(0, "R1 irq");
    // R2 register access
    wr(AR, 32'd5);            rd(AR, 32'd5, "R2 reload readback");
    wr(AC, 32'hF8FF_FFFF);    rd(AC, 0, "R2 ctrl reserved bits");
    wr(AN, 32'h0000_1234);    rd(AN, 0, "R2 count write ignored");
    wr(AC, 32'h0600_0000);    rd(AC, 32'h0600_0000, "R2 ctrl run+ien");
    wr(AC, 0);
    // R3 load and step
    wr(AC, 32'h0100_0000);    rd(AN, 5, "R3 load from reload");
    step(1);                  rd(AN, 4, "R3 step down");
    // R4 expiry
    step(3);                  rd(AN, 1, "R4 before expiry");
    step(1);                  rd(AN, 0, "R4 count at expiry");
    rd(AS, 32'h0100_0000, "R4 flag set");
    chk_irq(0, "R8 flag without enable");
    // R5 parked, R7 write zero
    step(5);                  rd(AN, 0, "R5 parked at zero");
    wr(AS, 0);                rd(AS, 32'h0100_0000, "R7 write zero no effect");
    rd(AN, 0, "R5 still parked");
    wr(AS, 32'h0100_0000);    rd(AS, 0, "R7 w1c clears");
    rd(AN, 5, "R5 reload on ack");
    // R8 late interrupt enable
    step(5);                  rd(AS, 32'h0100_0000, "R8 second expiry");
    chk_irq(0, "R8 irq masked");
    wr(AC, 32'h0300_0000);    chk_irq(1, "R8 irq after enable");
    rd(AN, 0, "R8 no reload on enable write");
    wr(AS, 32'h0100_0000);    chk_irq(0, "R8 irq drops on ack");
    rd(AN, 5, "R5 reload after ack");
    // R9 freeze
    step(2);                  rd(AN, 3, "R9 running");
    wr(AC, 32'h0200_0000);    rd(AN, 2, "R9 last step");
    step(3);                  rd(AN, 2, "R9 frozen");
    // R6 periodic
    wr(AC, 0); wr(AS, 32'h0100_0000); wr(AR, 32'd4);
    wr(AC, 32'h0500_0000);
    for (int k = 0; k < 12; k++) begin
      rd(AN, 32'(4 - (k % 4)), "R6 periodic count");
      if (k == 4) rd(AS, 32'h0100_0000, "R6 flag on periodic expiry");
      step(1);
    end
    // R10 clear coincides with expiry
    for (int k = 0; k < 8 && bus_rdata != 32'd1; k++) step(1);
    rd(AN, 1, "R10 poised at one");
    wr(AS, 32'h0100_0000);
    rd(AS, 32'h0100_0000, "R10 set wins over clear");
    rd(AN, 4, "R10 periodic reload");
    wr(AS, 32'h0100_0000);    rd(AS, 0, "R7 clear away from expiry");
    // R11 zero reload
    wr(AC, 0); wr(AR, 0); wr(AC, 32'h0100_0000); wr(AS, 32'h0100_0000);
    step(10);                 rd(AN, 0, "R11 zero reload count");
    rd(AS, 0, "R11 no expiry");
    step(2);
    finish_run();
  end
endmodule